// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus cycles of a 16-bit processor whose address and data share one set of pins. A requester offers one transaction at a time: a cycle kind (interrupt acknowledge, I/O read, I/O write, halt, instruction fetch, memory read, memory write or refresh), a 20-bit address, a word/byte flag, write data and a flag that tells the controller not to wait for READY. The controller accepts it only from its idle state and then steps through T1 (address out, ALE high), T2 (strobe and data setup), one or more T3 clocks (data strobe, READY sampled, each T3 with READY low repeats T3) and T4 (strobes released, cycle ends), before it returns to idle.

States: IDLE, T1, T2, T3, T4 and HOLD. Transitions: IDLE to T1 on an accepted request; IDLE to HOLD when hold is requested (hold wins over a pending request); T1 to T2 and T2 to T3 always; T3 to T3 while READY is low and READY is honoured; T3 to T4 when READY is high, when READY is ignored, or for a halt; T4 to IDLE always; HOLD to IDLE when the hold request drops. In HOLD the control pins float, the address/data pins are released and ALE is held low.

Pins that would be three-state on a package are brought out as a value plus an output enable, so the block stays purely digital.

Top module: `mbus_cycle_ctl`

## Requirements
- R1: The 3-bit status carries the cycle code in T1 and T2 and reads 111 (passive) in idle, T3, T4 and hold. Codes: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 fetch, 101 memory read, 110 memory write; a refresh cycle (kind 111) shows 101.
- R2: ALE is high for exactly the T1 clock; in T1 the AD pins carry address bits 15..1 plus the lane bit on AD[0], the address enable is on, and the upper pins carry address bits 19..16.
- R3: The upper address pins are 0 in every clock other than T1.
- R4: From T1 to T4 the pair (AD[0] in T1, BHE_n) is 0,0 for a word at an even address, 0,1 for an even byte, 1,0 for an odd byte or a word at an odd address, and 1,1 for refresh; BHE_n is 1 in idle.
- R5: RD_n is low in T2 and every T3 of a read-type cycle (interrupt acknowledge, I/O read, fetch, memory read, refresh) and WR_n in T2 and every T3 of a write cycle; both are high in T1, T4, idle and for halt.
- R6: When READY is honoured, each T3 clock in which READY is low is followed by another T3, so N low samples give N wait clocks; READY in any other state has no effect.
- R7: With the ignore-READY flag set, or for a halt, the cycle has exactly one T3 whatever READY does.
- R8: DEN_n is low in T2 and every T3 of any non-halt cycle and high everywhere else.
- R9: For writes the AD pins are driven with the write data from T2 through T4; for all other cycles the AD enable is off from T2 through T4.
- R10: Read data is captured from the AD inputs at the clock edge that ends the last T3 and presented with a read-valid strobe during T4; a done strobe is high only in T4.
- R11: While hold is granted the hold acknowledge is high, the control enable and AD enable are off, ALE is 0, and requests are not accepted; a hold request seen in idle wins over a simultaneous transaction request.
- R12: During reset the block is idle: status 111, ALE 0, RD_n, WR_n, DEN_n and BHE_n high, control enable on, no done and no hold acknowledge.
- R13: The request-ready output is high only in idle with no hold request, so a new cycle can start only after T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Controller can accept a request this clock |
| req_kind | input | 3 | Cycle kind, same code as status; 111 is refresh |
| req_addr | input | 20 | Transaction address |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_wdata | input | 16 | Write data |
| req_skip_ready | input | 1 | 1 = do not wait for READY in this cycle |
| ready_in | input | 1 | External READY, active high |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Hold granted, bus floated |
| status | output | 3 | Cycle status code |
| ale | output | 1 | Address latch enable |
| bhe_n | output | 1 | Upper byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| ctl_oe | output | 1 | Output enable for status, BHE_n, RD_n, WR_n, DEN_n and upper address |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable of the AD pins |
| ad_in | input | 16 | Multiplexed AD pins as seen from outside |
| a_hi | output | 4 | Upper address pins 19..16 |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | Read data valid (T4 of a read) |
| done | output | 1 | Cycle end strobe (T4) |

## Verification
Every cycle kind is run with word, even-byte and odd-byte lanes and with READY held low for a chosen number of T3 clocks, so a wrong status code, a wrong lane code and a wrong wait count each show up on a different pin. The AD input changes in every T3 clock, which separates capture at the last T3 from capture at an earlier one. Halt and ignore-READY cycles are run with READY held low to tell an honoured READY from an ignored one, and random kinds, addresses and delays follow the fixed table. Directed runs cover reset, hold entry and exit, and hold against a request in the same clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        OP_INTA    = 3'd0,
        OP_IORD    = 3'd1,
        OP_IOWR    = 3'd2,
        OP_HALT    = 3'd3,
        OP_FETCH   = 3'd4,
        OP_MEMRD   = 3'd5,
        OP_MEMWR   = 3'd6,
        OP_REFRESH = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_HOLD
    } phase_e;

    localparam logic [2:0] STAT_PASSIVE = 3'b111;
    localparam logic [2:0] STAT_MEMRD   = 3'b101;

    function automatic logic [2:0] status_of(op_e op);
        return (op == OP_REFRESH) ? STAT_MEMRD : logic'(op) ? 3'(op) : 3'(op);
    endfunction

    function automatic logic is_read(op_e op);
        return (op == OP_INTA) || (op == OP_IORD) || (op == OP_FETCH) ||
               (op == OP_MEMRD) || (op == OP_REFRESH);
    endfunction

    function automatic logic is_write(op_e op);
        return (op == OP_IOWR) || (op == OP_MEMWR);
    endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   hold_req,
    input  logic   ready_in,
    input  logic   skip_ready,
    output logic   req_ready,
    output logic   accept,
    output phase_e phase
);

    phase_e phase_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            ST_IDLE: begin
                if (hold_req) begin
                    phase_nx = ST_HOLD;
                end else if (req_valid) begin
                    phase_nx = ST_T1;
                end
            end
            ST_T1:   phase_nx = ST_T2;
            ST_T2:   phase_nx = ST_T3;
            ST_T3: begin
                if (skip_ready || ready_in) begin
                    phase_nx = ST_T4;
                end
            end
            ST_T4:   phase_nx = ST_IDLE;
            ST_HOLD: begin
                if (!hold_req) begin
                    phase_nx = ST_IDLE;
                end
            end
            default: phase_nx = ST_IDLE;
        endcase
    end

    assign req_ready = (phase == ST_IDLE) && !hold_req;
    assign accept    = req_ready && req_valid;

    // R6: a low READY that is honoured keeps the cycle in T3
    p_wait_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_T3 && !ready_in && !skip_ready) |=> (phase == ST_T3));

    // R13: T4 is always followed by idle
    p_t4_ends_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_T4) |=> (phase == ST_IDLE));

    // R11: hold persists while requested
    p_hold_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_HOLD && hold_req) |=> (phase == ST_HOLD));

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
    import mbus_pkg::*;
(
    input  op_e  op,
    input  logic word,
    input  logic addr0,
    output logic a0,
    output logic bhe_n
);

    always_comb begin
        if (op == OP_REFRESH) begin
            a0    = 1'b1;
            bhe_n = 1'b1;
        end else if (addr0) begin
            a0    = 1'b1;
            bhe_n = 1'b0;
        end else begin
            a0    = 1'b0;
            bhe_n = !word;
        end
    end

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_skip_ready,
    input  phase_e            phase,
    input  logic              ready_in,
    input  logic [DATA_W-1:0] ad_in,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              word_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              skip_ready,
    output logic [DATA_W-1:0] rdata
);

    logic skip_q;
    logic last_t3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_HALT;
            addr_q  <= '0;
            word_q  <= 1'b0;
            wdata_q <= '0;
            skip_q  <= 1'b0;
        end else if (accept) begin
            op_q    <= op_e'(req_kind);
            addr_q  <= req_addr;
            word_q  <= req_word;
            wdata_q <= req_wdata;
            skip_q  <= req_skip_ready;
        end
    end

    assign skip_ready = skip_q || (op_q == OP_HALT);
    assign last_t3    = (phase == ST_T3) && (skip_ready || ready_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (last_t3 && is_read(op_q)) begin
            rdata <= ad_in;
        end
    end

    // R13: the request latch only changes while idle
    p_latch_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE) |=> $stable(addr_q));

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lane_a0,
    input  logic              lane_bhe_n,
    output logic [2:0]        status,
    output logic              ale,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              done,
    output logic              rdata_valid,
    output logic              hold_ack
);

    always_comb begin
        status      = STAT_PASSIVE;
        ale         = 1'b0;
        bhe_n       = 1'b1;
        rd_n        = 1'b1;
        wr_n        = 1'b1;
        den_n       = 1'b1;
        ctl_oe      = 1'b1;
        ad_out      = '0;
        ad_oe       = 1'b0;
        a_hi        = '0;
        done        = 1'b0;
        rdata_valid = 1'b0;
        hold_ack    = 1'b0;
        unique case (phase)
            ST_IDLE: ;
            ST_T1: begin
                status = status_of(op);
                ale    = 1'b1;
                bhe_n  = lane_bhe_n;
                ad_oe  = 1'b1;
                ad_out = {addr[DATA_W-1:1], lane_a0};
                a_hi   = addr[ADDR_W-1:DATA_W];
            end
            ST_T2, ST_T3: begin
                if (phase == ST_T2) begin
                    status = status_of(op);
                end
                bhe_n = lane_bhe_n;
                rd_n  = !is_read(op);
                wr_n  = !is_write(op);
                den_n = (op == OP_HALT);
                if (is_write(op)) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata;
                end
            end
            ST_T4: begin
                bhe_n       = lane_bhe_n;
                done        = 1'b1;
                rdata_valid = is_read(op);
                if (is_write(op)) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata;
                end
            end
            ST_HOLD: begin
                ctl_oe   = 1'b0;
                hold_ack = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: the two strobes never overlap
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2: ALE is a single-clock pulse
    p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3: upper address returns to zero right after the address clock
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (a_hi == '0));

    // R11: floated bus while hold is granted
    p_hold_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ctl_oe && !ad_oe && !ale));

    // R1: the cycle end shows passive status
    p_end_passive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == STAT_PASSIVE));

    // R8: an active strobe always has the transceivers enabled
    p_den_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !den_n);

endmodule

// File: rtl/mbus_cycle_ctl.sv
module mbus_cycle_ctl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_skip_ready,
    input  logic              ready_in,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic [2:0]        status,
    output logic              ale,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              done
);

    phase_e            phase;
    logic              accept;
    logic              skip_ready;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              word_q;
    logic [DATA_W-1:0] wdata_q;
    logic              lane_a0;
    logic              lane_bhe_n;

    mbus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hold_req   (hold_req),
        .ready_in   (ready_in),
        .skip_ready (skip_ready),
        .req_ready  (req_ready),
        .accept     (accept),
        .phase      (phase)
    );

    mbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (accept),
        .req_kind       (req_kind),
        .req_addr       (req_addr),
        .req_word       (req_word),
        .req_wdata      (req_wdata),
        .req_skip_ready (req_skip_ready),
        .phase          (phase),
        .ready_in       (ready_in),
        .ad_in          (ad_in),
        .op_q           (op_q),
        .addr_q         (addr_q),
        .word_q         (word_q),
        .wdata_q        (wdata_q),
        .skip_ready     (skip_ready),
        .rdata          (rdata)
    );

    mbus_lane u_lane (
        .op    (op_q),
        .word  (word_q),
        .addr0 (addr_q[0]),
        .a0    (lane_a0),
        .bhe_n (lane_bhe_n)
    );

    mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .op          (op_q),
        .addr        (addr_q),
        .wdata       (wdata_q),
        .lane_a0     (lane_a0),
        .lane_bhe_n  (lane_bhe_n),
        .status      (status),
        .ale         (ale),
        .bhe_n       (bhe_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .den_n       (den_n),
        .ctl_oe      (ctl_oe),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .a_hi        (a_hi),
        .done        (done),
        .rdata_valid (rdata_valid),
        .hold_ack    (hold_ack)
    );

    // R11: no request is taken while hold is granted
    p_no_accept_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !req_ready);

endmodule

// File: tb/mbus_cycle_ctl_test.sv
`timescale 1ns/1ps
module mbus_cycle_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_skip_ready = 1'b0;
    logic        ready_in = 1'b0;
    logic        hold_req = 1'b0;
    logic        hold_ack;
    logic [2:0]  status;
    logic        ale, bhe_n, rd_n, wr_n, den_n, ctl_oe, ad_oe;
    logic [15:0] ad_out;
    logic [15:0] ad_in = '0;
    logic [3:0]  a_hi;
    logic [15:0] rdata;
    logic        rdata_valid, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;

    mbus_cycle_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_word(req_word),
        .req_wdata(req_wdata), .req_skip_ready(req_skip_ready),
        .ready_in(ready_in), .hold_req(hold_req), .hold_ack(hold_ack),
        .status(status), .ale(ale), .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n),
        .den_n(den_n), .ctl_oe(ctl_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .a_hi(a_hi), .rdata(rdata), .rdata_valid(rdata_valid),
        .done(done)
    );

    // vector: kind[43:41] word[40] addr[39:20] wdata[19:4] skip[3] waits[2:0]
    localparam int NVEC = 13;
    localparam logic [43:0] VEC [NVEC] = '{
        {3'd5, 1'b1, 20'h12340, 16'h0000, 1'b0, 3'd0},
        {3'd5, 1'b0, 20'hA5552, 16'h0000, 1'b0, 3'd2},
        {3'd5, 1'b0, 20'h0F0F1, 16'h0000, 1'b0, 3'd1},
        {3'd6, 1'b1, 20'h80000, 16'hBEEF, 1'b0, 3'd0},
        {3'd6, 1'b0, 20'h30003, 16'h00C3, 1'b0, 3'd3},
        {3'd1, 1'b0, 20'h00064, 16'h0000, 1'b0, 3'd1},
        {3'd2, 1'b1, 20'h00080, 16'h1234, 1'b0, 3'd2},
        {3'd4, 1'b1, 20'hFFFF0, 16'h0000, 1'b0, 3'd0},
        {3'd0, 1'b1, 20'h00000, 16'h0000, 1'b0, 3'd1},
        {3'd3, 1'b1, 20'h00000, 16'h0000, 1'b0, 3'd5},
        {3'd7, 1'b1, 20'h00400, 16'h0000, 1'b0, 3'd2},
        {3'd5, 1'b1, 20'h5A5A4, 16'h0000, 1'b1, 3'd4},
        {3'd6, 1'b1, 20'h01235, 16'h7E81, 1'b0, 3'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] lane_of(input logic [2:0] k, input logic w, input logic a0);
        if (k == 3'd7)  return 2'b11;
        if (a0)         return 2'b10;
        return w ? 2'b00 : 2'b01;
    endfunction

    task automatic run_op(input logic [2:0] k, input logic w, input logic [19:0] a,
                          input logic [15:0] d, input logic nr, input int wt);
        logic rdk, wrk, hlt;
        logic [1:0] lane;
        logic [15:0] rv;
        logic [2:0] st;
        int wexp;
        rdk  = (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd5) || (k == 3'd7);
        wrk  = (k == 3'd2) || (k == 3'd6);
        hlt  = (k == 3'd3);
        wexp = (hlt || nr) ? 0 : wt;
        lane = lane_of(k, w, a[0]);
        st   = (k == 3'd7) ? 3'b101 : k;
        rv   = 16'($urandom);

        @(negedge clk);
        check("R13 ready in idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_word = w;
        req_wdata = d; req_skip_ready = nr; ad_in = rv; ready_in = 1'b1;

        @(negedge clk); // T1
        req_valid = 1'b0;
        check("R1 status T1", 32'(status), 32'(st));
        check("R2 ale T1", 32'(ale), 1);
        check("R2 ad_oe T1", 32'(ad_oe), 1);
        check("R2 address T1", 32'(ad_out[15:1]), 32'(a[15:1]));
        check("R2 upper address T1", 32'(a_hi), 32'(a[19:16]));
        check("R4 lane code T1", 32'({ad_out[0], bhe_n}), 32'(lane));
        check("R5 strobes idle in T1", 32'({rd_n, wr_n}), 32'h3);
        check("R13 busy T1", 32'(req_ready), 0);

        @(negedge clk); // T2
        check("R1 status T2", 32'(status), 32'(st));
        check("R2 ale low T2", 32'(ale), 0);
        check("R3 upper zero T2", 32'(a_hi), 0);
        check("R4 bhe T2", 32'(bhe_n), 32'(lane[0]));
        check("R5 rd T2", 32'(rd_n), 32'(!rdk));
        check("R5 wr T2", 32'(wr_n), 32'(!wrk));
        check("R8 den T2", 32'(den_n), 32'(hlt));
        check("R9 ad_oe T2", 32'(ad_oe), 32'(wrk));
        if (wrk) check("R9 write data T2", 32'(ad_out), 32'(d));
        ready_in = 1'b0;

        for (int i = 0; i <= wexp; i++) begin
            @(negedge clk); // T3 number i
            check("R1 passive T3", 32'(status), 32'h7);
            check("R6 rd held in T3", 32'(rd_n), 32'(!rdk));
            check("R6 wr held in T3", 32'(wr_n), 32'(!wrk));
            check("R8 den T3", 32'(den_n), 32'(hlt));
            check("R3 upper zero T3", 32'(a_hi), 0);
            check("R9 ad_oe T3", 32'(ad_oe), 32'(wrk));
            ad_in    = rv ^ 16'(i);
            ready_in = (i == wexp) && !(hlt || nr);
        end

        @(negedge clk); // T4
        check("R6 R7 strobes released T4", 32'({rd_n, wr_n}), 32'h3);
        check("R8 den off T4", 32'(den_n), 1);
        check("R1 passive T4", 32'(status), 32'h7);
        check("R10 done T4", 32'(done), 1);
        check("R10 read valid T4", 32'(rdata_valid), 32'(rdk));
        if (rdk) check("R10 read data", 32'(rdata), 32'(rv ^ 16'(wexp)));
        check("R9 ad_oe T4", 32'(ad_oe), 32'(wrk));
        if (wrk) check("R9 write data T4", 32'(ad_out), 32'(d));
        check("R13 busy T4", 32'(req_ready), 0);
        ready_in = 1'b0;

        @(negedge clk); // idle
        check("R10 done cleared", 32'(done), 0);
        check("R13 ready again", 32'(req_ready), 1);
        check("R4 bhe idle", 32'(bhe_n), 1);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 status", 32'(status), 32'h7);
        check("R12 ale", 32'(ale), 0);
        check("R12 strobes", 32'({rd_n, wr_n, den_n, bhe_n}), 32'hF);
        check("R12 ctl_oe", 32'(ctl_oe), 1);
        check("R12 done/hold", 32'({done, hold_ack}), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v][43:41], VEC[v][40], VEC[v][39:20], VEC[v][19:4],
                   VEC[v][3], int'(VEC[v][2:0]));
        end

        for (int r = 0; r < 24; r++) begin
            run_op(3'($urandom_range(0, 7)), 1'($urandom), 20'($urandom),
                   16'($urandom), ($urandom_range(0, 3) == 0),
                   int'($urandom_range(0, 6)));
        end

        // R11 hold entry, floated bus, requests refused
        @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk);
        check("R11 hold ack", 32'(hold_ack), 1);
        check("R11 ctl float", 32'(ctl_oe), 0);
        check("R11 ad float", 32'(ad_oe), 0);
        check("R11 ale low", 32'(ale), 0);
        check("R11 not ready", 32'(req_ready), 0);
        req_valid = 1'b1; req_kind = 3'd5;
        @(negedge clk);
        check("R11 request ignored in hold", 32'({hold_ack, ale}), 32'h2);
        req_valid = 1'b0;
        hold_req  = 1'b0;
        @(negedge clk);
        check("R11 hold released", 32'({hold_ack, ctl_oe}), 32'h1);
        check("R11 idle after hold", 32'(status), 32'h7);

        // R11 hold beats a request in the same clock
        req_valid = 1'b1; hold_req = 1'b1; req_kind = 3'd6;
        @(negedge clk);
        check("R11 hold priority ack", 32'(hold_ack), 1);
        check("R11 hold priority no ale", 32'(ale), 0);
        req_valid = 1'b0; hold_req = 1'b0;
        @(negedge clk);
        check("R11 back to idle", 32'(req_ready), 1);

        // R7 ignore-READY write with READY low
        run_op(3'd6, 1'b1, 20'h44442, 16'hCAFE, 1'b1, 6);

        finish_run();
    end

endmodule